// File: doc/BRIEF.md
# SD host control register bank

This block is the 16-bit register file of an SD/MMC host controller. Software reaches it through a word-addressed read/write port, with read data returned one cycle after the request. It holds the card port selection, card option and timing fields, the stop-action controls, the clock control word that a separate clock generator consumes, the interrupt status and interrupt control words, and eight response words. The response words are filled by the command engine through a load port.

A software reset bit in the bank is active low. For as long as it reads 0, a fixed group of registers is held at set values every cycle, not just once on entry. Writes and hardware loads to that group have no effect. Registers outside the group keep whatever they held. After a power-on reset the bank comes up inside this software reset. Several fields read back differently from what was written: constant-one bits, bits that accept a write but read 0, and an identity field that depends on the instance.

Top module: `sdhost_regbank`

## Requirements
- R1: After hard reset (rst_n low), the bank reads: software reset word (offset 6) 0006h, port word (offset 0) 0201h, option word (offset 3) 40EEh, and all other words 0000h.
- R2: While software reset bit 0 is 0, the stop word (offset 1) and the interrupt control word (offset 5) read 0000h, and writes to them are ignored.
- R3: While software reset bit 0 is 0, the option word reads 40EEh regardless of writes. Clock control (offset 2) bits 8 and 10 read 0, while its other bits stay writable.
- R4: While software reset bit 0 is 0, the eight response words (offsets 8 to 15, word i at 8+i) read 0000h and response loads are ignored. Once released, a load of word i is read back at offset 8+i.
- R5: While software reset bit 0 is 0, the interrupt status word (offset 4) reads 0000h and interrupt events do not set it.
- R6: The port word and clock control bits other than 8 and 10 keep their values across entry into and exit from software reset.
- R7: The software reset word reads bits 2:1 as 1 and bits 15:3 as 0, and holds bit 0 as written.
- R8: In the port word, bits 3:0 are read/write, with bit 0 set to 1 selecting the onboard eMMC. Bits 9:8 read 10b for the SD instance whatever is written, bit 10 reads 0, and all other bits read 0.
- R9: Outside software reset, option bits 15 and 7:0 are read/write, bit 14 reads 1, and bits 13:8 read 0.
- R10: Outside software reset, stop word bits 8 (auto-stop enable) and 0 are read/write, and all other bits read 0.
- R11: Outside software reset, a 1 on irq_event bit k sets status flag k. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R12: A read presented with rd_en returns its data on rdata with rvalid high in the following cycle. rvalid is low otherwise, and offset 7 reads 0000h.
- R13: sdclk_div, sdclk_en, sdclk_freeze and clk_aux follow clock control bits 7:0, 8, 9 and 10. port_emmc follows port bit 0, bus_1bit follows option bit 15, and auto_stop_en follows stop bit 8. soft_reset_active is high while software reset bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read request |
| addr | input | 4 | Word offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, one cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| irq_event | input | 16 | Per-flag interrupt set pulses |
| resp_we | input | 1 | Response word load strobe |
| resp_sel | input | 3 | Response word index |
| resp_wdata | input | 16 | Response word load data |
| sdclk_div | output | 8 | Clock divider select |
| sdclk_en | output | 1 | Clock output enable |
| sdclk_freeze | output | 1 | Clock freeze control |
| clk_aux | output | 1 | Auxiliary clock control bit |
| port_emmc | output | 1 | 1 selects onboard eMMC, 0 selects the card slot |
| bus_1bit | output | 1 | 1 selects a 1-bit data bus, 0 a 4-bit bus |
| auto_stop_en | output | 1 | Automatic stop command after the block count |
| soft_reset_active | output | 1 | Software reset is being held |

## Verification
The hardest case to reach is the collision of an interrupt event with a clearing write to the same flag in one cycle, together with the boundary cycles around entry into and exit from software reset. Directed sequences drive an event and a status write on the same clock edge. They also write forced registers, load responses and pulse events while the reset is held, then release it and read everything back. A seeded random phase mixes writes to all offsets, including the software reset word, with events, response loads and reads. Each read is compared against a bench model built from the requirements.

// File: rtl/sdhost_pkg.sv
// Package: shared constants of the SD host register bank.
// Assumes 16-bit data words and word offsets below 16.
package sdhost_pkg;
    localparam int DATA_W      = 16;
    localparam int NUM_RESP    = 8;
    localparam int NUM_REGS    = 7;
    localparam int RESP_BASE   = 8;
    localparam int CLK_BITS    = 11;
    localparam int CLK_EN_BIT  = 8;
    localparam int CLK_FRZ_BIT = 9;
    localparam int CLK_AUX_BIT = 10;

    // word offsets of the control registers
    localparam int A_PORT  = 0;
    localparam int A_STOP  = 1;
    localparam int A_CLK   = 2;
    localparam int A_OPT   = 3;
    localparam int A_ISTAT = 4;
    localparam int A_ICTL  = 5;
    localparam int A_SRST  = 6;

    localparam logic [7:0]          OPT_LO_FORCE   = 8'hEE;
    localparam logic [CLK_BITS-1:0] CLK_FORCE_MASK =
        CLK_BITS'((1 << CLK_EN_BIT) | (1 << CLK_AUX_BIT));
endpackage

// File: rtl/sdhost_decode.sv
// Module: turns a write strobe and word offset into one-hot register strobes.
// Assumes the register offsets are 0..NREG-1.
module sdhost_decode #(
    parameter int ADDR_W = 4,
    parameter int NREG   = 7
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);
    // one comparator per register offset
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i] = wr_en && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/sdhost_ctrl_regs.sv
// Module: port select, stop action, clock control, option and soft reset state.
// Assumes the write strobes are already decoded. srst_q low holds the forced values.
module sdhost_ctrl_regs
    import sdhost_pkg::*;
#(
    parameter bit IS_SDIO = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_port,
    input  logic                we_stop,
    input  logic                we_clk,
    input  logic                we_opt,
    input  logic                we_srst,
    input  logic [CLK_BITS-1:0] wd_lo,
    input  logic                wd_msb,
    output logic                srst_q,
    output logic [3:0]          port_q,
    output logic                stop_auto_q,
    output logic                stop_b0_q,
    output logic [CLK_BITS-1:0] clk_q,
    output logic                opt_wide_q,
    output logic [7:0]          opt_lo_q
);
    localparam logic [3:0] PORT_RST = IS_SDIO ? 4'h0 : 4'h1;

    // soft reset release bit, starts in reset after a hard reset
    always_ff @(posedge clk) begin
        if (!rst_n)       srst_q <= 1'b0;
        else if (we_srst) srst_q <= wd_lo[0];
    end

    // port select field, not touched by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)       port_q <= PORT_RST;
        else if (we_port) port_q <= wd_lo[3:0];
    end

    // stop action bits, held at zero during soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || !srst_q) begin
            stop_auto_q <= 1'b0;
            stop_b0_q   <= 1'b0;
        end else if (we_stop) begin
            stop_auto_q <= wd_lo[8];
            stop_b0_q   <= wd_lo[0];
        end
    end

    // clock control, enable and aux bits cleared while soft reset holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= '0;
        end else begin
            if (we_clk)  clk_q <= wd_lo;
            if (!srst_q) begin
                clk_q[CLK_EN_BIT]  <= 1'b0;
                clk_q[CLK_AUX_BIT] <= 1'b0;
            end
        end
    end

    // card option fields, forced to the reset pattern during soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || !srst_q) begin
            opt_wide_q <= 1'b0;
            opt_lo_q   <= OPT_LO_FORCE;
        end else if (we_opt) begin
            opt_wide_q <= wd_msb;
            opt_lo_q   <= wd_lo[7:0];
        end
    end
endmodule

// File: rtl/sdhost_irq_regs.sv
// Module: interrupt status flags and interrupt control word.
// Assumes a set event has priority over a clearing write and that soft reset clears both.
module sdhost_irq_regs #(
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_srst,
    input  logic             we_stat,
    input  logic             we_ctl,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [IRQ_W-1:0] irq_event,
    output logic [IRQ_W-1:0] stat_q,
    output logic [IRQ_W-1:0] ctl_q
);
    logic [IRQ_W-1:0] keep;

    // a written zero acknowledges a flag, a written one keeps it
    always_comb keep = we_stat ? (stat_q & wdata) : stat_q;

    // status flags: events set them, write-zero clears them, soft reset wipes them
    always_ff @(posedge clk) begin
        if (!rst_n || in_srst) stat_q <= '0;
        else                   stat_q <= keep | irq_event;
    end

    // interrupt control word, cleared during soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || in_srst) ctl_q <= '0;
        else if (we_ctl)       ctl_q <= wdata;
    end
endmodule

// File: rtl/sdhost_resp_buf.sv
// Module: response word storage loaded by the command engine.
// Assumes loads during soft reset are dropped and the words are zeroed then.
module sdhost_resp_buf #(
    parameter int DATA_W   = 16,
    parameter int NUM_RESP = 8,
    localparam int IDX_W   = $clog2(NUM_RESP)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_srst,
    input  logic                             load,
    input  logic [IDX_W-1:0]                 sel,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_RESP-1:0][DATA_W-1:0]  words
);
    for (genvar i = 0; i < NUM_RESP; i++) begin : g_word
        // one response word, zero-filled while soft reset holds
        always_ff @(posedge clk) begin
            if (!rst_n || in_srst)                    words[i] <= '0;
            else if (load && (sel == IDX_W'(i)))      words[i] <= wdata;
        end
    end
endmodule

// File: rtl/sdhost_regbank.sv
// Module: top of the SD host register bank. Decodes accesses, builds the read
// view with its constant and masked bits, and drives the control outputs.
// Assumes one access per cycle and a read latency of one cycle.
module sdhost_regbank
    import sdhost_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter bit IS_SDIO = 1'b0,
    localparam int RIDX_W = $clog2(NUM_RESP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic [DATA_W-1:0] irq_event,
    input  logic              resp_we,
    input  logic [RIDX_W-1:0] resp_sel,
    input  logic [DATA_W-1:0] resp_wdata,
    output logic [7:0]        sdclk_div,
    output logic              sdclk_en,
    output logic              sdclk_freeze,
    output logic              clk_aux,
    output logic              port_emmc,
    output logic              bus_1bit,
    output logic              auto_stop_en,
    output logic              soft_reset_active
);
    localparam logic [1:0] PORT_ID = IS_SDIO ? 2'b01 : 2'b10;

    logic [NUM_REGS-1:0]               wsel;
    logic                              srst_q;
    logic                              in_srst;
    logic [3:0]                        port_q;
    logic                              stop_auto_q;
    logic                              stop_b0_q;
    logic [CLK_BITS-1:0]               clk_q;
    logic [CLK_BITS-1:0]               clk_view;
    logic                              opt_wide_q;
    logic [7:0]                        opt_lo_q;
    logic [DATA_W-1:0]                 istat_q;
    logic [DATA_W-1:0]                 ictl_q;
    logic [NUM_RESP-1:0][DATA_W-1:0]   resp_q;
    logic [ADDR_W-1:0]                 resp_off;
    logic                              is_resp;
    logic [DATA_W-1:0]                 rd_next;

    assign in_srst = !srst_q;

    sdhost_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (wsel)
    );

    sdhost_ctrl_regs #(.IS_SDIO(IS_SDIO)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_port     (wsel[A_PORT]),
        .we_stop     (wsel[A_STOP]),
        .we_clk      (wsel[A_CLK]),
        .we_opt      (wsel[A_OPT]),
        .we_srst     (wsel[A_SRST]),
        .wd_lo       (wdata[CLK_BITS-1:0]),
        .wd_msb      (wdata[DATA_W-1]),
        .srst_q      (srst_q),
        .port_q      (port_q),
        .stop_auto_q (stop_auto_q),
        .stop_b0_q   (stop_b0_q),
        .clk_q       (clk_q),
        .opt_wide_q  (opt_wide_q),
        .opt_lo_q    (opt_lo_q)
    );

    sdhost_irq_regs #(.IRQ_W(DATA_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_srst   (in_srst),
        .we_stat   (wsel[A_ISTAT]),
        .we_ctl    (wsel[A_ICTL]),
        .wdata     (wdata),
        .irq_event (irq_event),
        .stat_q    (istat_q),
        .ctl_q     (ictl_q)
    );

    sdhost_resp_buf #(.DATA_W(DATA_W), .NUM_RESP(NUM_RESP)) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_srst (in_srst),
        .load    (resp_we),
        .sel     (resp_sel),
        .wdata   (resp_wdata),
        .words   (resp_q)
    );

    // clock control as seen by readers and the clock generator
    always_comb clk_view = in_srst ? (clk_q & ~CLK_FORCE_MASK) : clk_q;

    // response window detection
    always_comb begin
        resp_off = addr - ADDR_W'(RESP_BASE);
        is_resp  = (int'(addr) >= RESP_BASE) && (int'(addr) < RESP_BASE + NUM_RESP);
    end

    // read data selection with constant and forced bits applied
    always_comb begin
        rd_next = '0;
        if (is_resp) begin
            rd_next = in_srst ? '0 : resp_q[RIDX_W'(resp_off)];
        end else begin
            case (int'(addr))
                A_PORT:  rd_next = {6'b0, PORT_ID, 4'b0, port_q};
                A_STOP:  rd_next = in_srst ? '0 : {7'b0, stop_auto_q, 7'b0, stop_b0_q};
                A_CLK:   rd_next = {{(DATA_W-CLK_BITS){1'b0}}, clk_view};
                A_OPT:   rd_next = in_srst ? {8'h40, OPT_LO_FORCE}
                                           : {opt_wide_q, 1'b1, 6'b0, opt_lo_q};
                A_ISTAT: rd_next = in_srst ? '0 : istat_q;
                A_ICTL:  rd_next = in_srst ? '0 : ictl_q;
                A_SRST:  rd_next = {13'b0, 2'b11, srst_q};
                default: rd_next = '0;
            endcase
        end
    end

    // registered read port, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rdata  <= rd_en ? rd_next : '0;
            rvalid <= rd_en;
        end
    end

    assign sdclk_div         = clk_view[7:0];
    assign sdclk_en          = clk_view[CLK_EN_BIT];
    assign sdclk_freeze      = clk_view[CLK_FRZ_BIT];
    assign clk_aux           = clk_view[CLK_AUX_BIT];
    assign port_emmc         = port_q[0];
    assign bus_1bit          = !in_srst && opt_wide_q;
    assign auto_stop_en      = !in_srst && stop_auto_q;
    assign soft_reset_active = in_srst;
endmodule

// File: rtl/sdhost_regbank_chk.sv
// Module: property checker bound into the register bank.
// Assumes it sees the stored register values before any read masking.
module sdhost_regbank_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_srst,
    input logic              rd_en,
    input logic              rvalid,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       rdata,
    input logic [15:0]       irq_event,
    input logic [15:0]       istat_q,
    input logic [15:0]       ictl_q,
    input logic              stop_auto_q,
    input logic              stop_b0_q,
    input logic              opt_wide_q,
    input logic [7:0]        opt_lo_q,
    input logic [10:0]       clk_q
);
    // R2: stop and interrupt control stored as zero after a soft reset cycle
    a_r2_forced_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_srst |=> (!stop_auto_q && !stop_b0_q && ictl_q == 16'h0));

    // R3: option pattern and cleared clock bits after a soft reset cycle
    a_r3_option_clock: assert property (@(posedge clk) disable iff (!rst_n)
        in_srst |=> (!opt_wide_q && opt_lo_q == 8'hEE && !clk_q[8] && !clk_q[10]));

    // R5: status flags wiped while soft reset holds
    a_r5_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        in_srst |=> (istat_q == 16'h0));

    // R11: an event always leaves its flag set in the next cycle
    a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !in_srst |=> ((istat_q & $past(irq_event)) == $past(irq_event)));

    // R12: read valid follows the request by one cycle
    a_r12_rvalid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    a_r12_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R7: constant bits of the soft reset word on every read of it
    a_r7_srst_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(6)) |=> (rdata[15:1] == 15'd3));
endmodule

bind sdhost_regbank sdhost_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_srst     (in_srst),
    .rd_en       (rd_en),
    .rvalid      (rvalid),
    .addr        (addr),
    .rdata       (rdata),
    .irq_event   (irq_event),
    .istat_q     (istat_q),
    .ictl_q      (ictl_q),
    .stop_auto_q (stop_auto_q),
    .stop_b0_q   (stop_b0_q),
    .opt_wide_q  (opt_wide_q),
    .opt_lo_q    (opt_lo_q),
    .clk_q       (clk_q)
);

// File: tb/tb_sdhost_regbank.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module tb_sdhost_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic [15:0] irq_event = '0;
    logic        resp_we = 1'b0;
    logic [2:0]  resp_sel = '0;
    logic [15:0] resp_wdata = '0;
    logic [7:0]  sdclk_div;
    logic        sdclk_en, sdclk_freeze, clk_aux, port_emmc, bus_1bit;
    logic        auto_stop_en, soft_reset_active;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [3:0]  m_port;
    logic        m_stop8, m_stop0, m_opt15, m_srst;
    logic [10:0] m_clk;
    logic [7:0]  m_optlo;
    logic [15:0] m_irq, m_mask;
    logic [15:0] m_resp [8];

    always #4 clk = ~clk;

    sdhost_regbank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq_event(irq_event),
        .resp_we(resp_we), .resp_sel(resp_sel), .resp_wdata(resp_wdata),
        .sdclk_div(sdclk_div), .sdclk_en(sdclk_en), .sdclk_freeze(sdclk_freeze),
        .clk_aux(clk_aux), .port_emmc(port_emmc), .bus_1bit(bus_1bit),
        .auto_stop_en(auto_stop_en), .soft_reset_active(soft_reset_active)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic void model_hard_reset();
        m_port = 4'h1; m_stop8 = 0; m_stop0 = 0; m_opt15 = 0; m_optlo = 8'hEE;
        m_clk = '0; m_irq = '0; m_mask = '0; m_srst = 0;
        for (int i = 0; i < 8; i++) m_resp[i] = '0;
    endfunction

    function automatic void model_force();
        m_stop8 = 0; m_stop0 = 0; m_opt15 = 0; m_optlo = 8'hEE;
        m_irq = '0; m_mask = '0; m_clk[8] = 0; m_clk[10] = 0;
        for (int i = 0; i < 8; i++) m_resp[i] = '0;
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
        case (a)
            4'd0: m_port = d[3:0];
            4'd1: if (m_srst) begin m_stop8 = d[8]; m_stop0 = d[0]; end
            4'd2: begin m_clk = d[10:0]; if (!m_srst) begin m_clk[8] = 0; m_clk[10] = 0; end end
            4'd3: if (m_srst) begin m_opt15 = d[15]; m_optlo = d[7:0]; end
            4'd4: if (m_srst) m_irq = m_irq & d;
            4'd5: if (m_srst) m_mask = d;
            4'd6: begin m_srst = d[0]; if (!m_srst) model_force(); end
            default: ;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0: return {6'b0, 2'b10, 4'b0, m_port};
            4'd1: return m_srst ? {7'b0, m_stop8, 7'b0, m_stop0} : 16'h0;
            4'd2: return {5'b0, m_clk};
            4'd3: return m_srst ? {m_opt15, 1'b1, 6'b0, m_optlo} : 16'h40EE;
            4'd4: return m_srst ? m_irq : 16'h0;
            4'd5: return m_srst ? m_mask : 16'h0;
            4'd6: return {13'b0, 2'b11, m_srst};
            4'd7: return 16'h0;
            default: return m_srst ? m_resp[a - 4'd8] : 16'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0: return "R8";
            4'd1: return m_srst ? "R10" : "R2";
            4'd2: return m_srst ? "R6" : "R3";
            4'd3: return m_srst ? "R9" : "R3";
            4'd4: return m_srst ? "R11" : "R5";
            4'd5: return "R2";
            4'd6: return "R7";
            4'd7: return "R12";
            default: return "R4";
        endcase
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input logic [3:0] a);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0;
        chk("R12 rvalid", {15'b0, rvalid}, 16'h1);
        chk(req_of(a), rdata, exp_rd(a));
    endtask

    task automatic ev(input logic [15:0] v);
        @(negedge clk); irq_event = v;
        @(negedge clk); irq_event = '0;
        if (m_srst) m_irq = m_irq | v;
    endtask

    task automatic ev_clr(input logic [15:0] v, input logic [15:0] d);
        @(negedge clk); irq_event = v; wr_en = 1; addr = 4'd4; wdata = d;
        @(negedge clk); irq_event = '0; wr_en = 0;
        if (m_srst) m_irq = (m_irq & d) | v;
    endtask

    task automatic rload(input logic [2:0] i, input logic [15:0] d);
        @(negedge clk); resp_we = 1; resp_sel = i; resp_wdata = d;
        @(negedge clk); resp_we = 0;
        if (m_srst) m_resp[i] = d;
    endtask

    task automatic chk_outs();
        chk("R13 div", {8'b0, sdclk_div}, {8'b0, m_clk[7:0]});
        chk("R13 ctl", {9'b0, sdclk_en, sdclk_freeze, clk_aux, port_emmc, bus_1bit,
                        auto_stop_en, soft_reset_active},
            {9'b0, m_clk[8], m_clk[9], m_clk[10], m_port[0], m_srst & m_opt15,
             m_srst & m_stop8, !m_srst});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5D1C));
        model_hard_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: state after hard reset
        for (int a = 0; a < 16; a++) begin
            @(negedge clk); rd_en = 1; addr = 4'(a);
            @(negedge clk); rd_en = 0;
            chk("R1", rdata, exp_rd(4'(a)));
        end
        chk_outs();
        // writes and loads while soft reset holds
        wr(4'd1, 16'hFFFF); rd_chk(4'd1);                 // R2
        wr(4'd5, 16'hFFFF); rd_chk(4'd5);                 // R2
        wr(4'd3, 16'hBF11); rd_chk(4'd3);                 // R3
        wr(4'd2, 16'h07FF); rd_chk(4'd2);                 // R3 reads 02FF
        chk("R3 clk", exp_rd(4'd2), 16'h02FF);
        ev(16'hFFFF); rd_chk(4'd4);                       // R5
        rload(3'd2, 16'h1234); rd_chk(4'd10);             // R4
        wr(4'd0, 16'h040A); rd_chk(4'd0);                 // R8 reads 020A
        chk_outs();
        // release soft reset
        wr(4'd6, 16'hFFFF); rd_chk(4'd6);                 // R7 reads 0007
        rd_chk(4'd0); rd_chk(4'd2);                       // R6
        rd_chk(4'd1); rd_chk(4'd3); rd_chk(4'd10);        // forced values persist
        wr(4'd3, 16'hFFFF); rd_chk(4'd3);                 // R9 reads C0FF
        wr(4'd1, 16'hFFFF); rd_chk(4'd1);                 // R10 reads 0101
        wr(4'd2, 16'h0512); rd_chk(4'd2);
        chk_outs();                                       // R13
        // R11: set, clear, collision
        ev(16'h00F0); rd_chk(4'd4);
        wr(4'd4, 16'hFF0F); rd_chk(4'd4);
        ev(16'h0011);
        ev_clr(16'h0010, 16'h0000); rd_chk(4'd4);
        chk("R11 collision", exp_rd(4'd4), 16'h0010);
        wr(4'd5, 16'hA5A5); rd_chk(4'd5);
        rload(3'd3, 16'hABCD); rd_chk(4'd11);             // R4
        rd_chk(4'd7);                                     // R12 unmapped
        @(negedge clk);
        chk("R12 idle", {15'b0, rvalid}, 16'h0);
        // re-enter soft reset
        wr(4'd6, 16'h0000);
        for (int a = 0; a < 16; a++) rd_chk(4'(a));
        chk_outs();
        wr(4'd6, 16'h0001);
        for (int a = 0; a < 16; a++) rd_chk(4'(a));
        // random phase
        for (int it = 0; it < 600; it++) begin
            logic [3:0] a;
            logic [15:0] d;
            a = 4'($urandom_range(0, 15));
            d = 16'($urandom);
            case ($urandom_range(0, 5))
                0: if (a != 4'd6 || $urandom_range(0, 3) == 0) wr(a, d);
                1: rd_chk(a);
                2: ev(16'($urandom) & 16'($urandom));
                3: rload(3'($urandom_range(0, 7)), d);
                4: ev_clr(16'($urandom) & 16'($urandom), d);
                default: chk_outs();
            endcase
        end
        for (int a = 0; a < 16; a++) rd_chk(4'(a));
        done = 1'b1;
        summary();
        $finish;
    end
endmodule